// File: doc/BRIEF.md
# Reloadable Periodic Interrupt Timer

This block is a down-counting timer on a small register bus. Its typical use is as a preemption tick for a processor. Software selects one of three externally generated tick enables, loads a modulus, and picks a compare value. The counter then steps down by one on every selected tick. When a tick arrives while the count equals the compare value, a sticky status flag is set. If the interrupt enable is on, that flag drives a level interrupt until software clears it by writing a one.

Three independent control bits shape how the counter behaves:
- One makes a modulus write overwrite the running count at once.
- One chooses between reloading from the modulus at zero and wrapping to all ones.
- One makes a rising run bit restart the count from the modulus instead of resuming from the held value.

The tick enables are produced outside the block, and no prescaling is done here.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset, every register reads zero (control, modulus, compare, status, count) and `irq` is low.
- R2: Control bit 0 (run) gates counting. Control bits [6:5] choose the tick source: 1 selects `tick_pclk`, 2 selects `tick_fast`, 3 selects `tick_slow`, and 0 selects none. While run is set, the count decreases by exactly one on each cycle in which the chosen tick is high. The other tick inputs have no effect.
- R3: Writing zero to the control register stops the timer. After that write, ticks leave the count unchanged.
- R4: With control bit 4 (overwrite) set, a write to the modulus register (address 1) also puts the written value into the count on the same clock edge. This holds whether or not the timer is running.
- R5: With control bit 4 clear, a modulus write changes only the modulus, and the count is left as it was.
- R6: With control bit 3 (reload) set, a tick taken at count zero loads the count from the modulus.
- R7: With control bit 3 clear, a tick taken at count zero wraps the count to all ones, and counting continues down from there.
- R8: A control write that turns run from 0 to 1 with control bit 1 (restart) set loads the count from the modulus. Without bit 1, the held count is kept.
- R9: A tick taken while the count equals the compare register (address 2) sets status bit 0 on that edge. With a compare value of zero, the event fires on the tick taken at count zero.
- R10: Writing 1 to status bit 0 (address 3) clears the flag. Writing 0 leaves it set. A compare event in the same cycle as the clear wins.
- R11: `irq` is high exactly while status bit 0 and control bit 2 (interrupt enable) are both set.
- R12: Reads are combinational from `bus_addr`: 0 control, 1 modulus, 2 compare, 3 status, 4 current count. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write (1) or read (0) |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| tick_pclk | input | 1 | Tick enable, source code 1 |
| tick_fast | input | 1 | Tick enable, source code 2 |
| tick_slow | input | 1 | Tick enable, source code 3 |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the counter's next value on every cycle:
- a single decrement per accepted tick;
- reload or wrap at zero, depending on the reload bit;
- overwrite on a modulus write;
- a stable count when nothing touches it.

They also check, every cycle, that a compare event sets the flag, that a write-one clear without a coinciding event drops it, and that the interrupt never rises without the flag.

Only the bench's scenarios can show the following:
- register decoding;
- the effect of the source select;
- the difference between restarting and resuming on a rising run bit;
- the full sequence from a loaded modulus through zero to a reload and an interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PCLK = 2'd1,
    SRC_FAST = 2'd2,
    SRC_SLOW = 2'd3
  } tick_src_e;

  // Bit layout, MSB first: src[6:5], overwrite[4], reload[3], irq_en[2], restart[1], run[0]
  typedef struct packed {
    tick_src_e src;
    logic      overwrite;
    logic      reload;
    logic      irq_en;
    logic      restart;
    logic      run;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  localparam int A_CTRL   = 0;
  localparam int A_MOD    = 1;
  localparam int A_CMP    = 2;
  localparam int A_STAT   = 3;
  localparam int A_COUNT  = 4;

endpackage

// File: rtl/tmr_tick_mux.sv
module tmr_tick_mux
  import tmr_pkg::*;
(
  input  tick_src_e sel,
  input  logic      tick_pclk,
  input  logic      tick_fast,
  input  logic      tick_slow,
  output logic      tick
);

  always_comb begin
    unique case (sel)
      SRC_PCLK: tick = tick_pclk;
      SRC_FAST: tick = tick_fast;
      SRC_SLOW: tick = tick_slow;
      default:  tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_fire,
  input  logic         ow_load,
  input  logic [W-1:0] load_val,
  input  logic         restart_load,
  input  logic [W-1:0] modulus,
  input  logic         reload_mode,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] count,
  output logic         cmp_hit
);

  function automatic logic [W-1:0] step_down(input logic [W-1:0] cur,
                                             input logic [W-1:0] modv,
                                             input logic         rel);
    if (cur == '0) return rel ? modv : '1;
    return cur - W'(1);
  endfunction

  logic [W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (ow_load)           count_d = load_val;
    else if (restart_load) count_d = modulus;
    else if (tick_fire)    count_d = step_down(count, modulus, reload_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  assign cmp_hit = tick_fire && (count == cmp_val);

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_pclk,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);

  localparam int PAD_W = DATA_W - CTRL_W;

  tmr_ctrl_t   ctrl_q;
  tmr_ctrl_t   ctrl_wr;
  logic [DATA_W-1:0] mod_q;
  logic [DATA_W-1:0] cmp_q;
  logic [DATA_W-1:0] count;

  logic wr_en;
  logic wr_ctrl, wr_mod, wr_cmp, wr_stat;
  logic tick_sel, tick_fire;
  logic ow_load, restart_load, run_rise;
  logic cmp_hit, stat_clr, flag;

  assign wr_en   = bus_sel && bus_we;
  assign wr_ctrl = wr_en && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_mod  = wr_en && (bus_addr == ADDR_W'(A_MOD));
  assign wr_cmp  = wr_en && (bus_addr == ADDR_W'(A_CMP));
  assign wr_stat = wr_en && (bus_addr == ADDR_W'(A_STAT));
  assign ctrl_wr = tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mod_q  <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_wr;
      if (wr_mod)  mod_q  <= bus_wdata;
      if (wr_cmp)  cmp_q  <= bus_wdata;
    end
  end

  tmr_tick_mux u_mux (
    .sel       (ctrl_q.src),
    .tick_pclk (tick_pclk),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .tick      (tick_sel)
  );

  assign tick_fire    = ctrl_q.run && tick_sel;
  assign ow_load      = wr_mod && ctrl_q.overwrite;
  assign run_rise     = wr_ctrl && ctrl_wr.run && !ctrl_q.run;
  assign restart_load = run_rise && ctrl_wr.restart;

  tmr_count_core #(.W(DATA_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_fire    (tick_fire),
    .ow_load      (ow_load),
    .load_val     (bus_wdata),
    .restart_load (restart_load),
    .modulus      (mod_q),
    .reload_mode  (ctrl_q.reload),
    .cmp_val      (cmp_q),
    .count        (count),
    .cmp_hit      (cmp_hit)
  );

  assign stat_clr = wr_stat && bus_wdata[0];

  tmr_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (cmp_hit),
    .clr   (stat_clr),
    .flag  (flag)
  );

  assign irq = flag && ctrl_q.irq_en;

  always_comb begin
    bus_rdata = '0;
    unique case (int'(bus_addr))
      A_CTRL:  bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
      A_MOD:   bus_rdata = mod_q;
      A_CMP:   bus_rdata = cmp_q;
      A_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, flag};
      A_COUNT: bus_rdata = count;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_fire,
  input logic         ow_load,
  input logic         restart_load,
  input logic         reload_mode,
  input logic [W-1:0] load_val,
  input logic [W-1:0] modulus,
  input logic [W-1:0] count,
  input logic         cmp_hit,
  input logic         stat_clr,
  input logic         flag,
  input logic         irq
);

  logic quiet;
  assign quiet = !ow_load && !restart_load;

  p_overwrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ow_load |=> count == $past(load_val));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !tick_fire) |=> $stable(count));

  p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && tick_fire && count != '0) |=> count == $past(count) - W'(1));

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && tick_fire && count == '0 && reload_mode) |=> count == $past(modulus));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && tick_fire && count == '0 && !reload_mode) |=> &count);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> flag);

  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !cmp_hit) |=> !flag);

  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !irq);

endmodule

bind periodic_tick_timer tmr_checker #(.W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_fire    (tick_fire),
  .ow_load      (ow_load),
  .restart_load (restart_load),
  .reload_mode  (ctrl_q.reload),
  .load_val     (bus_wdata),
  .modulus      (mod_q),
  .count        (count),
  .cmp_hit      (cmp_hit),
  .stat_clr     (stat_clr),
  .flag         (flag),
  .irq          (irq)
);

// File: tb/test_periodic_tick_timer.sv
module test_periodic_tick_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_pclk = 1'b0;
  logic        tick_fast = 1'b0;
  logic        tick_slow = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  bit rd_active = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  periodic_tick_timer i_periodic_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_pclk(tick_pclk), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .irq(irq)
  );

  // Monitor: pops expected read data and compares
  always @(negedge clk) begin
    if (rd_active && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read addr %0d got %h expected %h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    rd_active = 1'b1;
    @(negedge clk); #1;
    rd_active = 1'b0;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_checks++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  // src: 1 pclk, 2 fast, 3 slow; n selected edges with the tick high
  task automatic pulse(input int src, input int n);
    @(posedge clk); #1;
    case (src)
      1: tick_pclk = 1'b1;
      2: tick_fast = 1'b1;
      default: tick_slow = 1'b1;
    endcase
    repeat (n) @(posedge clk);
    #1;
    tick_pclk = 1'b0; tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(0, 32'h0, "R1 ctrl");
    rd(1, 32'h0, "R1 modulus");
    rd(2, 32'h0, "R1 compare");
    rd(3, 32'h0, "R1 status");
    rd(4, 32'h0, "R1 count");
    chk_irq(1'b0, "R1 irq");

    // R12 decode
    rd(5, 32'h0, "R12 unmapped");
    wr(2, 32'h55);
    rd(2, 32'h55, "R12 compare readback");

    // R4 overwrite while stopped; R2 run gating
    wr(0, 32'h10);
    wr(1, 32'd10);
    rd(4, 32'd10, "R4 overwrite stopped");
    pulse(1, 3);
    rd(4, 32'd10, "R2 no count without run");

    // R5 modulus only
    wr(0, 32'h00);
    wr(1, 32'd20);
    rd(4, 32'd10, "R5 count kept");
    rd(1, 32'd20, "R5 modulus updated");

    // R8 restart from modulus, source pclk
    wr(0, 32'h23);
    rd(4, 32'd20, "R8 restart load");
    pulse(2, 4);
    pulse(3, 4);
    rd(4, 32'd20, "R2 other sources ignored");
    pulse(1, 5);
    rd(4, 32'd15, "R2 decrement per tick");

    // R3 stop
    wr(0, 32'h00);
    rd(0, 32'h00, "R3 ctrl zero");
    pulse(1, 3);
    rd(4, 32'd15, "R3 stopped holds");

    // R8 resume without restart, slow source
    wr(0, 32'h61);
    rd(4, 32'd15, "R8 resume keeps count");
    pulse(3, 2);
    rd(4, 32'd13, "R2 slow source");

    // R9 compare event
    wr(2, 32'd12);
    pulse(3, 1);
    rd(3, 32'd0, "R9 no event before match");
    pulse(3, 1);
    rd(4, 32'd11, "R2 count after match");
    rd(3, 32'd1, "R9 flag on match");
    chk_irq(1'b0, "R11 masked");
    wr(0, 32'h65);
    chk_irq(1'b1, "R11 enabled");
    wr(3, 32'h0);
    rd(3, 32'd1, "R10 write zero keeps");
    wr(3, 32'h1);
    rd(3, 32'd0, "R10 write one clears");
    chk_irq(1'b0, "R11 cleared");

    // R6 reload, compare at zero
    wr(0, 32'h10);
    wr(1, 32'd3);
    wr(2, 32'd0);
    wr(0, 32'h2D);
    rd(4, 32'd3, "R4 overwrite then run");
    pulse(1, 3);
    rd(4, 32'd0, "R2 reached zero");
    rd(3, 32'd0, "R9 not yet at zero");
    pulse(1, 1);
    rd(4, 32'd3, "R6 reload");
    rd(3, 32'd1, "R9 event at zero");
    chk_irq(1'b1, "R11 after reload event");
    wr(3, 32'h1);

    // R7 wrap
    wr(0, 32'h25);
    pulse(1, 3);
    pulse(1, 1);
    rd(4, 32'hFFFF_FFFF, "R7 wrap");
    rd(3, 32'd1, "R9 event on wrap");
    pulse(1, 1);
    rd(4, 32'hFFFF_FFFE, "R7 continue down");

    // R4 overwrite while running
    wr(0, 32'h35);
    wr(1, 32'd7);
    rd(4, 32'd7, "R4 overwrite running");

    done = 1;
    summary();
    $finish;
  end

endmodule